// File: doc/BRIEF.md
# Loop Trip-Count Predictor

This block learns how many times each loop's closing branch runs before the loop exits. It then supplies a direction for that branch that is exact on every iteration, including the exit. A fetch stage presents a lookup address together with the direction chosen by its ordinary predictor. The block returns a final direction and a flag that says whether it replaced that ordinary choice. It replaces the choice only for branches it has seen close a loop the same way several times in a row. Every other branch passes through unchanged.

Resolved branches come back on a valid/ready port. Each transfer carries the branch address, the real outcome and whether the branch jumps backward. Ready is held high at all times, so the port never applies back-pressure. Every cycle with valid high is a transfer and updates the state at the next clock edge. Resolves must arrive in program order, and each executed branch must be reported exactly once. The table has a fixed number of fully associative entries, each tagged with the full branch address. Each entry holds a trip limit, a running iteration count and a two-bit confidence counter. Entries are replaced in round-robin order.

Top module: `loop_trip_predictor`

## Requirements
- R1: After reset no entry is valid: `pred_override` is 0 and `pred_taken` equals `base_taken` for every lookup address, and `resolve_ready` is 1.
- R2: When the lookup address hits an entry whose confidence is 3, `pred_override` is 1. In that case `pred_taken` is 1 when count+1 is below the limit and 0 when count+1 equals or exceeds it, whatever `base_taken` is.
- R3: When the lookup misses, or hits an entry with confidence below 3, `pred_override` is 0 and `pred_taken` equals `base_taken`.
- R4: An entry is allocated only by a resolve that misses, is taken, has `resolve_backward`=1, and carries the same address as the most recent earlier resolve that was both taken and backward. The new entry starts with count 0, limit 0 and confidence 0. Forward branches and backward branches that do not repeat back to back never allocate.
- R5: A taken resolve that hits adds one to that entry's count. The count saturates at 2^CNT_W-2, which is 1022 by default.
- R6: A not-taken resolve that hits clears the count. If count+1 equals the stored limit, confidence goes up by one and saturates at 3. Otherwise the limit becomes count+1 and confidence drops to 0.
- R7: Allocation uses a round-robin victim pointer that starts at entry 0 and advances by one per allocation, wrapping after ENTRIES-1. The ninth distinct allocation evicts the first entry.
- R8: Lookup is combinational on the current state. A resolve changes that state only at the next rising clock edge.
- R9: On a hit, the backward flag of a resolve has no effect: the update is the same for backward=0 and backward=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | PC_W | Address of the branch being predicted |
| base_taken | input | 1 | Direction from the ordinary predictor |
| pred_taken | output | 1 | Final predicted direction |
| pred_override | output | 1 | 1 when the loop table replaced base_taken |
| resolve_valid | input | 1 | Resolved-branch transfer present |
| resolve_ready | output | 1 | Always 1; no back-pressure |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |
| resolve_backward | input | 1 | 1 when the branch target is below its address |

## Verification
The bound checker watches properties that hold on every cycle. An override always sits on a lookup hit. Tags never match twice. Allocations occur only on missing backward-taken resolves. A taken hit steps the count by exactly one below saturation, and a not-taken hit leaves the count at zero. Learning the trip count, confidence reaching three after matching exits, the exact exit prediction, the saturation corner, round-robin eviction, and the refusal to allocate for forward or interleaved branches take multi-run histories, so only the bench's scenarios can show them.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_FULL = '1;

  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_ALLOC,
    UPD_STEP,
    UPD_CLOSE
  } upd_kind_e;

  function automatic logic [CONF_W-1:0] conf_bump(input logic [CONF_W-1:0] c);
    return (c == CONF_FULL) ? c : c + CONF_W'(1);
  endfunction
endpackage

// File: rtl/lp_match.sv
module lp_match #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]           vld,
  input  logic [ENTRIES-1:0][PC_W-1:0] tags,
  input  logic [PC_W-1:0]              pc,
  output logic [ENTRIES-1:0]           match,
  output logic                         hit,
  output logic [IDX_W-1:0]             idx
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld[i] && (tags[i] == pc);
  end

  assign hit = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/lp_alloc.sv
module lp_alloc #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [PC_W-1:0]  pc,
  input  logic             taken,
  input  logic             bwd,
  input  logic             hit,
  output logic             alloc_en,
  output logic [IDX_W-1:0] alloc_idx
);
  logic            prev_vld;
  logic [PC_W-1:0] prev_pc;
  logic [IDX_W-1:0] victim;
  logic            back_taken;
  logic            repeat_seen;

  assign back_taken  = fire && bwd && taken;
  assign repeat_seen = prev_vld && (prev_pc == pc);
  assign alloc_en    = back_taken && !hit && repeat_seen;
  assign alloc_idx   = victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_vld <= 1'b0;
      prev_pc  <= '0;
    end else if (back_taken) begin
      prev_vld <= 1'b1;
      prev_pc  <= pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim <= '0;
    end else if (alloc_en) begin
      victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + IDX_W'(1);
    end
  end
endmodule

// File: rtl/lp_table.sv
module lp_table
  import lp_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  upd_kind_e                          kind,
  input  logic [IDX_W-1:0]                   upd_idx,
  input  logic [PC_W-1:0]                    upd_pc,
  output logic [ENTRIES-1:0]                 vld,
  output logic [ENTRIES-1:0][PC_W-1:0]       tags,
  output logic [ENTRIES-1:0][CNT_W-1:0]      lim,
  output logic [ENTRIES-1:0][CNT_W-1:0]      cnt,
  output logic [ENTRIES-1:0][CONF_W-1:0]     conf
);
  localparam logic [CNT_W-1:0] CNT_SAT = {{(CNT_W-1){1'b1}}, 1'b0};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    logic [CNT_W-1:0] cnt_inc;
    assign sel     = (upd_idx == IDX_W'(i));
    assign cnt_inc = cnt[i] + CNT_W'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i]  <= 1'b0;
        tags[i] <= '0;
        lim[i]  <= '0;
        cnt[i]  <= '0;
        conf[i] <= '0;
      end else if (sel) begin
        case (kind)
          UPD_ALLOC: begin
            vld[i]  <= 1'b1;
            tags[i] <= upd_pc;
            lim[i]  <= '0;
            cnt[i]  <= '0;
            conf[i] <= '0;
          end
          UPD_STEP: begin
            if (cnt[i] != CNT_SAT) cnt[i] <= cnt_inc;
          end
          UPD_CLOSE: begin
            if (cnt_inc == lim[i]) begin
              conf[i] <= conf_bump(conf[i]);
            end else begin
              lim[i]  <= cnt_inc;
              conf[i] <= '0;
            end
            cnt[i] <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/loop_trip_predictor.sv
module loop_trip_predictor
  import lp_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lookup_pc,
  input  logic            base_taken,
  output logic            pred_taken,
  output logic            pred_override,
  input  logic            resolve_valid,
  output logic            resolve_ready,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken,
  input  logic            resolve_backward
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0][PC_W-1:0]   ent_tag;
  logic [ENTRIES-1:0][CNT_W-1:0]  ent_lim;
  logic [ENTRIES-1:0][CNT_W-1:0]  ent_cnt;
  logic [ENTRIES-1:0][CONF_W-1:0] ent_conf;

  logic [ENTRIES-1:0] lk_match, rs_match;
  logic               lk_hit, rs_hit;
  logic [IDX_W-1:0]   lk_idx, rs_idx;
  logic               res_fire;
  logic               alloc_en;
  logic [IDX_W-1:0]   alloc_idx;
  upd_kind_e          kind;
  logic [IDX_W-1:0]   upd_idx;

  assign resolve_ready = 1'b1;
  assign res_fire      = resolve_valid && resolve_ready;

  lp_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_lk_match (
    .vld(ent_vld), .tags(ent_tag), .pc(lookup_pc),
    .match(lk_match), .hit(lk_hit), .idx(lk_idx)
  );

  lp_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_rs_match (
    .vld(ent_vld), .tags(ent_tag), .pc(resolve_pc),
    .match(rs_match), .hit(rs_hit), .idx(rs_idx)
  );

  lp_alloc #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .fire(res_fire), .pc(resolve_pc),
    .taken(resolve_taken), .bwd(resolve_backward), .hit(rs_hit),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx)
  );

  always_comb begin
    kind    = UPD_NONE;
    upd_idx = rs_idx;
    if (res_fire) begin
      if (alloc_en) begin
        kind    = UPD_ALLOC;
        upd_idx = alloc_idx;
      end else if (rs_hit) begin
        kind = resolve_taken ? UPD_STEP : UPD_CLOSE;
      end
    end
  end

  lp_table #(.ENTRIES(ENTRIES), .PC_W(PC_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .kind(kind), .upd_idx(upd_idx),
    .upd_pc(resolve_pc), .vld(ent_vld), .tags(ent_tag),
    .lim(ent_lim), .cnt(ent_cnt), .conf(ent_conf)
  );

  logic [CNT_W-1:0]  sel_cnt, sel_lim;
  logic [CONF_W-1:0] sel_conf;
  logic [CNT_W:0]    iter_no;
  logic              keep_going;

  assign sel_cnt    = ent_cnt[lk_idx];
  assign sel_lim    = ent_lim[lk_idx];
  assign sel_conf   = ent_conf[lk_idx];
  assign iter_no    = {1'b0, sel_cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign keep_going = iter_no < {1'b0, sel_lim};

  assign pred_override = lk_hit && (sel_conf == CONF_FULL);
  assign pred_taken    = pred_override ? keep_going : base_taken;
endmodule

// File: rtl/lp_chk.sv
module lp_chk #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          pred_override,
  input logic                          resolve_taken,
  input logic                          resolve_backward,
  input logic                          res_fire,
  input logic                          lk_hit,
  input logic [ENTRIES-1:0]            lk_match,
  input logic                          rs_hit,
  input logic [IDX_W-1:0]              rs_idx,
  input logic                          alloc_en,
  input logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt
);
  localparam logic [CNT_W-1:0] CNT_SAT = {{(CNT_W-1){1'b1}}, 1'b0};

  // R2
  override_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_override |-> lk_hit);

  // R3
  miss_no_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> !pred_override);

  // R4
  alloc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (res_fire && resolve_backward && resolve_taken && !rs_hit));

  // R7
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fire && rs_hit && resolve_taken && ent_cnt[rs_idx] != CNT_SAT)
      |=> ent_cnt[$past(rs_idx)] == $past(ent_cnt[rs_idx]) + CNT_W'(1));

  // R6
  close_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fire && rs_hit && !resolve_taken) |=> ent_cnt[$past(rs_idx)] == '0);
endmodule

bind loop_trip_predictor lp_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W), .CNT_W(CNT_W)) u_lp_chk (
  .clk(clk), .rst_n(rst_n), .pred_override(pred_override),
  .resolve_taken(resolve_taken), .resolve_backward(resolve_backward),
  .res_fire(res_fire), .lk_hit(lk_hit), .lk_match(lk_match),
  .rs_hit(rs_hit), .rs_idx(rs_idx), .alloc_en(alloc_en), .ent_cnt(ent_cnt)
);

// File: tb/test_loop_trip_predictor.sv
module test_loop_trip_predictor;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lookup_pc = '0;
  logic base_taken = 1'b0;
  logic pred_taken, pred_override;
  logic resolve_valid = 1'b0;
  logic resolve_ready;
  logic [PC_W-1:0] resolve_pc = '0;
  logic resolve_taken = 1'b0;
  logic resolve_backward = 1'b0;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  loop_trip_predictor i_loop_trip_predictor (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .base_taken(base_taken),
    .pred_taken(pred_taken), .pred_override(pred_override),
    .resolve_valid(resolve_valid), .resolve_ready(resolve_ready),
    .resolve_pc(resolve_pc), .resolve_taken(resolve_taken),
    .resolve_backward(resolve_backward)
  );

  localparam logic [PC_W-1:0] PC_A = 32'h0000_4a10;
  localparam logic [PC_W-1:0] PC_B = 32'h0000_5b20;
  localparam logic [PC_W-1:0] PC_C = 32'h0000_6c30;
  localparam logic [PC_W-1:0] PC_F = 32'h0000_7d40;

  typedef struct packed {
    logic base;
    logic taken;
    logic bwd;
    logic exp_pred;
    logic exp_ovr;
  } vec_t;

  // One confident run of loop A (trip 5); rows 1 and 2 resolve with backward=0 (R9)
  localparam vec_t [0:4] VEC = '{
    '{base: 1'b0, taken: 1'b1, bwd: 1'b1, exp_pred: 1'b1, exp_ovr: 1'b1},
    '{base: 1'b1, taken: 1'b1, bwd: 1'b0, exp_pred: 1'b1, exp_ovr: 1'b1},
    '{base: 1'b0, taken: 1'b1, bwd: 1'b0, exp_pred: 1'b1, exp_ovr: 1'b1},
    '{base: 1'b0, taken: 1'b1, bwd: 1'b1, exp_pred: 1'b1, exp_ovr: 1'b1},
    '{base: 1'b1, taken: 1'b0, bwd: 1'b1, exp_pred: 1'b0, exp_ovr: 1'b1}
  };

  task automatic cmp(input logic ap, input logic ao, input logic ep, input logic eo,
                     input string req);
    n_vec++;
    if (ap !== ep || ao !== eo) begin
      n_bad++;
      $display("FAIL %s: pred=%b ovr=%b expected pred=%b ovr=%b", req, ap, ao, ep, eo);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input logic base,
                      input logic ep, input logic eo, input string req);
    @(negedge clk);
    lookup_pc  = pc;
    base_taken = base;
    #1;
    cmp(pred_taken, pred_override, ep, eo, req);
  endtask

  task automatic res(input logic [PC_W-1:0] pc, input logic t, input logic b);
    @(negedge clk);
    resolve_pc       = pc;
    resolve_taken    = t;
    resolve_backward = b;
    resolve_valid    = 1'b1;
    @(posedge clk);
    #1;
    resolve_valid = 1'b0;
  endtask

  task automatic run_loop(input logic [PC_W-1:0] pc, input int trips, input logic b);
    for (int k = 0; k < trips - 1; k++) res(pc, 1'b1, b);
    res(pc, 1'b0, b);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty table passes base through, ready high
    look(PC_A, 1'b1, 1'b1, 1'b0, "R1");
    look(PC_A, 1'b0, 1'b0, 1'b0, "R1");
    n_vec++;
    if (resolve_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: resolve_ready=%b expected 1", resolve_ready);
    end

    // R4/R6: first run allocates and mislearns, next runs build confidence
    for (int r = 0; r < 4; r++) run_loop(PC_A, 5, 1'b1);
    // R3: confidence 2, still pass-through
    look(PC_A, 1'b0, 1'b0, 1'b0, "R3");
    run_loop(PC_A, 5, 1'b1);

    // R2/R8/R9: vector walk, lookup checked while the resolve is pending
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      lookup_pc        = PC_A;
      base_taken       = VEC[i].base;
      resolve_pc       = PC_A;
      resolve_taken    = VEC[i].taken;
      resolve_backward = VEC[i].bwd;
      resolve_valid    = 1'b1;
      #1;
      cmp(pred_taken, pred_override, VEC[i].exp_pred, VEC[i].exp_ovr, "R2_R8_R9");
      @(posedge clk);
      #1;
      resolve_valid = 1'b0;
    end
    look(PC_A, 1'b0, 1'b1, 1'b1, "R6");

    // R6: different trip count drops confidence, relearns limit 3
    run_loop(PC_A, 3, 1'b1);
    look(PC_A, 1'b1, 1'b1, 1'b0, "R6");
    for (int r = 0; r < 3; r++) run_loop(PC_A, 3, 1'b1);
    look(PC_A, 1'b0, 1'b1, 1'b1, "R2");
    res(PC_A, 1'b1, 1'b1);
    look(PC_A, 1'b0, 1'b1, 1'b1, "R2");
    res(PC_A, 1'b1, 1'b1);
    look(PC_A, 1'b1, 1'b0, 1'b1, "R2");
    res(PC_A, 1'b0, 1'b1);

    // R5: count saturation at 1022, limit learns 1023
    for (int r = 0; r < 4; r++) run_loop(PC_A, 1101, 1'b1);
    for (int k = 0; k < 1021; k++) res(PC_A, 1'b1, 1'b1);
    look(PC_A, 1'b0, 1'b1, 1'b1, "R5");
    res(PC_A, 1'b1, 1'b1);
    look(PC_A, 1'b1, 1'b0, 1'b1, "R5");
    for (int k = 0; k < 8; k++) res(PC_A, 1'b1, 1'b1);
    look(PC_A, 1'b1, 1'b0, 1'b1, "R5");
    res(PC_A, 1'b0, 1'b1);
    look(PC_A, 1'b0, 1'b1, 1'b1, "R5");

    // R4: forward branch never allocates
    for (int r = 0; r < 6; r++) run_loop(PC_F, 3, 1'b0);
    look(PC_F, 1'b0, 1'b0, 1'b0, "R4");
    // R4: interleaved backward branches never repeat back to back
    for (int r = 0; r < 6; r++) begin
      res(PC_B, 1'b1, 1'b1);
      res(PC_C, 1'b1, 1'b1);
      res(PC_B, 1'b0, 1'b1);
      res(PC_C, 1'b0, 1'b1);
    end
    look(PC_B, 1'b0, 1'b0, 1'b0, "R4");
    look(PC_C, 1'b1, 1'b1, 1'b0, "R4");

    // R7: seven more allocations fill entries 1..7, the eighth evicts A
    for (int p = 1; p <= 7; p++) begin
      res(32'h0001_0000 + PC_W'(p * 16), 1'b1, 1'b1);
      res(32'h0001_0000 + PC_W'(p * 16), 1'b1, 1'b1);
      res(32'h0001_0000 + PC_W'(p * 16), 1'b0, 1'b1);
    end
    look(PC_A, 1'b0, 1'b1, 1'b1, "R7");
    res(32'h0002_0000, 1'b1, 1'b1);
    res(32'h0002_0000, 1'b1, 1'b1);
    look(PC_A, 1'b0, 1'b0, 1'b0, "R7");
    look(PC_A, 1'b1, 1'b1, 1'b0, "R7");

    finish_run();
  end
endmodule